// File: doc/BRIEF.md
# Snooping Tag Controller for a Four-Way Data Cache

This block keeps the address tags and line states of a four-way set-associative data cache with 16-byte lines and 64 sets. The processor side presents a lookup (address plus a read/write flag). One cycle after the lookup is accepted, the block reports hit or miss, the way involved and the resulting line state. On a miss it picks a victim way and raises a miss request toward a separate refill engine. The miss request says whether the victim holds dirty data that must be written back. When the engine acknowledges, the block installs the new tag. The block does not store line data.

A second port watches a synchronous external bus that other masters drive. Each cycle on that bus carries a flag that says whether it may be snooped. The block samples a cycle only on rising edges where the bus clock-enable is high. A snoopable cycle that matches a resident line invalidates that line. The snooper has priority over the processor for the tag array: a processor lookup in the same cycle is stalled and then retried on the next free cycle.

Top module: `snoop_tag_ctrl`

## Requirements
- R1: After reset every line is invalid, `rsp_vld` and `miss_req_vld` are low, and the first lookup to any address misses.
- R2: An accepted lookup (request high, stall low at the edge) gives `rsp_vld` for one cycle on the next cycle. Address bits [9:4] select the set and bits [31:10] form the tag. A hit reports the way that holds the tag.
- R3: A miss reports `rsp_hit`=0, `rsp_state`=00 and `rsp_way` equal to the victim. `miss_req_vld` then stays high, with `miss_addr` (the line address, low four bits zero) and `miss_way` held stable, until `miss_ack`. While it is high, every processor request is stalled.
- R4: At `miss_ack` the victim way takes the new tag. Its state becomes clean (01) after a read miss and dirty (11) after a write miss.
- R5: Line state codes: 00 invalid, 01 clean, 11 dirty. A write hit leaves the line dirty and reports 11. A read hit reports the state and does not change it.
- R6: The victim is the lowest-numbered invalid way. If no way is invalid, a per-set round-robin pointer picks the way. The pointer starts at 0 and advances by one only on fills that used it.
- R7: `miss_wb` is high exactly when the chosen victim is dirty.
- R8: A snoop with `bus_ce`, `snp_vld` and `snp_snoopable` all high invalidates the line that matches its address. A later lookup of that line misses.
- R9: A bus cycle with `snp_snoopable` low, or sampled while `bus_ce` is low, leaves tags and states unchanged.
- R10: A processor request in the same cycle as an accepted snoop sees `cpu_stall` high and gets no response for that cycle. It is served on the next free cycle and sees the state after the invalidation.
- R11: Address bits [3:0] do not affect a lookup. Two offsets within one line hit the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_vld | input | 1 | Processor lookup request, held until not stalled |
| cpu_addr | input | 32 | Lookup byte address |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_stall | output | 1 | Request not taken this cycle |
| rsp_vld | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 2 | Hit way, or victim way on a miss |
| rsp_state | output | 2 | Line state after the access (00 on a miss) |
| miss_req_vld | output | 1 | Refill request pending |
| miss_addr | output | 32 | Line address to refill |
| miss_way | output | 2 | Way that the refill replaces |
| miss_wb | output | 1 | Victim is dirty and needs writeback |
| miss_ack | input | 1 | Refill engine done; install tag |
| bus_ce | input | 1 | External bus clock-enable |
| snp_vld | input | 1 | Another master drives a bus cycle |
| snp_snoopable | input | 1 | Bus cycle is marked snoopable |
| snp_addr | input | 32 | Bus cycle address |

## Verification
The hardest case to reach is a snoop and a processor lookup that collide in the same cycle on the same line, because the retried lookup must see the post-invalidation state. The bench drives both in one cycle and checks the stall first. It then expects a miss with the invalidated way chosen as the victim. The round-robin pointer is reached only after filling all four ways of a set with mixed clean and dirty lines. A snoop then opens a hole, so the fill after it must prefer the hole over the pointer and must not advance the pointer.

// File: rtl/snc_pkg.sv
package snc_pkg;
  typedef enum logic [1:0] {
    LN_INV   = 2'b00,
    LN_CLEAN = 2'b01,
    LN_DIRTY = 2'b11
  } ln_st_e;
endpackage

// File: rtl/snc_way_cmp.sv
module snc_way_cmp
  import snc_pkg::*;
#(
  parameter int TAG_W = 22,
  parameter int WAY_N = 4,
  localparam int WAY_W = $clog2(WAY_N)
) (
  input  logic [WAY_N-1:0][TAG_W-1:0] row_tag,
  input  logic [WAY_N-1:0][1:0]       row_st,
  input  logic [TAG_W-1:0]            key_tag,
  output logic [WAY_N-1:0]            hit_vec,
  output logic [WAY_W-1:0]            hit_way
);
  for (genvar w = 0; w < WAY_N; w++) begin : g_way
    assign hit_vec[w] = (row_st[w] != LN_INV) && (row_tag[w] == key_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAY_N; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/snc_victim.sv
module snc_victim
  import snc_pkg::*;
#(
  parameter int WAY_N = 4,
  localparam int WAY_W = $clog2(WAY_N)
) (
  input  logic [WAY_N-1:0][1:0] row_st,
  input  logic [WAY_W-1:0]      rr_ptr,
  output logic [WAY_W-1:0]      vic_way,
  output logic                  vic_full,
  output logic                  vic_dirty
);
  always_comb begin
    vic_full = 1'b1;
    vic_way  = rr_ptr;
    for (int w = WAY_N - 1; w >= 0; w--) begin
      if (row_st[w] == LN_INV) begin
        vic_full = 1'b0;
        vic_way  = WAY_W'(w);
      end
    end
    vic_dirty = (row_st[vic_way] == LN_DIRTY);
  end
endmodule

// File: rtl/snc_tag_store.sv
module snc_tag_store
  import snc_pkg::*;
#(
  parameter int SET_W = 6,
  parameter int TAG_W = 22,
  parameter int WAY_N = 4,
  localparam int WAY_W = $clog2(WAY_N),
  localparam int SETS  = 1 << SET_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            a_set,
  output logic [WAY_N-1:0][TAG_W-1:0] a_tag,
  output logic [WAY_N-1:0][1:0]       a_st,
  output logic [WAY_W-1:0]            a_rr,
  input  logic [SET_W-1:0]            b_set,
  output logic [WAY_N-1:0][TAG_W-1:0] b_tag,
  output logic [WAY_N-1:0][1:0]       b_st,
  input  logic                        inv_en,
  input  logic [SET_W-1:0]            inv_set,
  input  logic [WAY_W-1:0]            inv_way,
  input  logic                        upd_en,
  input  logic [SET_W-1:0]            upd_set,
  input  logic [WAY_W-1:0]            upd_way,
  input  logic                        fill_en,
  input  logic [SET_W-1:0]            fill_set,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic [1:0]                  fill_st,
  input  logic                        rr_adv
);
  logic [SETS-1:0][WAY_N-1:0][TAG_W-1:0] tag_q;
  logic [SETS-1:0][WAY_N-1:0][1:0]       st_q, st_d;
  logic [SETS-1:0][WAY_W-1:0]            rr_q, rr_d;

  assign a_tag = tag_q[a_set];
  assign a_st  = st_q[a_set];
  assign a_rr  = rr_q[a_set];
  assign b_tag = tag_q[b_set];
  assign b_st  = st_q[b_set];

  always_comb begin
    st_d = st_q;
    rr_d = rr_q;
    if (upd_en)  st_d[upd_set][upd_way]   = LN_DIRTY;
    if (inv_en)  st_d[inv_set][inv_way]   = LN_INV;
    if (fill_en) st_d[fill_set][fill_way] = fill_st;
    if (fill_en && rr_adv) rr_d[fill_set] = rr_q[fill_set] + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      rr_q <= '0;
    end else begin
      st_q <= st_d;
      rr_q <= rr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_set][fill_way] <= fill_tag;
  end

  assert_snoop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en && !(fill_en && fill_set == inv_set && fill_way == inv_way)
    |=> st_q[$past(inv_set)][$past(inv_way)] == LN_INV);

  assert_idle_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_en && !upd_en && !fill_en |=> $stable(st_q) && $stable(rr_q));
endmodule

// File: rtl/snoop_tag_ctrl.sv
module snoop_tag_ctrl
  import snc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int SET_W  = 6,
  parameter int WAY_N  = 4,
  localparam int TAG_W = ADDR_W - SET_W - OFF_W,
  localparam int WAY_W = $clog2(WAY_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_vld,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  output logic              cpu_stall,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [1:0]        rsp_state,
  output logic              miss_req_vld,
  output logic [ADDR_W-1:0] miss_addr,
  output logic [WAY_W-1:0]  miss_way,
  output logic              miss_wb,
  input  logic              miss_ack,
  input  logic              bus_ce,
  input  logic              snp_vld,
  input  logic              snp_snoopable,
  input  logic [ADDR_W-1:0] snp_addr
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [SET_W-1:0] cpu_set, snp_set;
  logic [TAG_W-1:0] cpu_tag, snp_tag;
  logic             unused_offset;
  assign cpu_set = cpu_addr[OFF_W +: SET_W];
  assign cpu_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign snp_set = snp_addr[OFF_W +: SET_W];
  assign snp_tag = snp_addr[ADDR_W-1 -: TAG_W];
  assign unused_offset = ^{cpu_addr[OFF_W-1:0], snp_addr[OFF_W-1:0]};

  logic [WAY_N-1:0][TAG_W-1:0] a_tag, b_tag;
  logic [WAY_N-1:0][1:0]       a_st, b_st;
  logic [WAY_W-1:0]            a_rr;
  logic [WAY_N-1:0]            cpu_hit_vec, snp_hit_vec;
  logic [WAY_W-1:0]            cpu_hit_way, snp_hit_way;
  logic [WAY_W-1:0]            vic_way;
  logic                        vic_full, vic_dirty;

  // miss tracking registers
  logic             pend_q, pend_d;
  logic [SET_W-1:0] pset_q;
  logic [TAG_W-1:0] ptag_q;
  logic [WAY_W-1:0] pway_q;
  logic             pwr_q, pwb_q, padv_q;
  // response registers
  logic             rvld_q, rhit_q;
  logic [WAY_W-1:0] rway_q, rway_d;
  logic [1:0]       rst_q, rst_d;

  logic snoop_go, accept, cpu_hit, miss_take, fill_en, inv_en, upd_en;

  assign snoop_go  = bus_ce & snp_vld & snp_snoopable;
  assign inv_en    = snoop_go & (|snp_hit_vec);
  assign accept    = cpu_req_vld & ~snoop_go & ~pend_q;
  assign cpu_stall = cpu_req_vld & (snoop_go | pend_q);
  assign cpu_hit   = |cpu_hit_vec;
  assign upd_en    = accept & cpu_hit & cpu_wr;
  assign miss_take = accept & ~cpu_hit;
  assign fill_en   = pend_q & miss_ack;

  snc_way_cmp #(.TAG_W(TAG_W), .WAY_N(WAY_N)) u_cmp_cpu (
    .row_tag(a_tag), .row_st(a_st), .key_tag(cpu_tag),
    .hit_vec(cpu_hit_vec), .hit_way(cpu_hit_way));

  snc_way_cmp #(.TAG_W(TAG_W), .WAY_N(WAY_N)) u_cmp_snp (
    .row_tag(b_tag), .row_st(b_st), .key_tag(snp_tag),
    .hit_vec(snp_hit_vec), .hit_way(snp_hit_way));

  snc_victim #(.WAY_N(WAY_N)) u_victim (
    .row_st(a_st), .rr_ptr(a_rr),
    .vic_way(vic_way), .vic_full(vic_full), .vic_dirty(vic_dirty));

  snc_tag_store #(.SET_W(SET_W), .TAG_W(TAG_W), .WAY_N(WAY_N)) u_store (
    .clk(clk), .rst_n(rst_int_n),
    .a_set(cpu_set), .a_tag(a_tag), .a_st(a_st), .a_rr(a_rr),
    .b_set(snp_set), .b_tag(b_tag), .b_st(b_st),
    .inv_en(inv_en), .inv_set(snp_set), .inv_way(snp_hit_way),
    .upd_en(upd_en), .upd_set(cpu_set), .upd_way(cpu_hit_way),
    .fill_en(fill_en), .fill_set(pset_q), .fill_way(pway_q), .fill_tag(ptag_q),
    .fill_st(pwr_q ? LN_DIRTY : LN_CLEAN), .rr_adv(padv_q));

  always_comb begin
    pend_d = pend_q;
    if (miss_take)    pend_d = 1'b1;
    else if (fill_en) pend_d = 1'b0;
    rway_d = cpu_hit ? cpu_hit_way : vic_way;
    if (!cpu_hit)    rst_d = LN_INV;
    else if (cpu_wr) rst_d = LN_DIRTY;
    else             rst_d = a_st[cpu_hit_way];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q <= 1'b0;
      rvld_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      rvld_q <= accept;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rhit_q <= cpu_hit;
      rway_q <= rway_d;
      rst_q  <= rst_d;
    end
    if (miss_take) begin
      pset_q <= cpu_set;
      ptag_q <= cpu_tag;
      pway_q <= vic_way;
      pwr_q  <= cpu_wr;
      pwb_q  <= vic_dirty;
      padv_q <= vic_full;
    end
  end

  assign rsp_vld      = rvld_q;
  assign rsp_hit      = rhit_q;
  assign rsp_way      = rway_q;
  assign rsp_state    = rst_q;
  assign miss_req_vld = pend_q;
  assign miss_addr    = {ptag_q, pset_q, {OFF_W{1'b0}}};
  assign miss_way     = pway_q;
  assign miss_wb      = pwb_q;

  assert_tag_unique_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(cpu_hit_vec));

  assert_hit_has_state_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_vld && rsp_hit |-> rsp_state != LN_INV);

  assert_miss_held_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    miss_req_vld && !miss_ack |=> miss_req_vld && $stable(miss_addr) && $stable(miss_way));

  assert_pending_blocks_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    miss_req_vld |=> !rsp_vld);

  assert_snoop_wins_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    snoop_go |=> !rsp_vld);
endmodule

// File: tb/snoop_tag_ctrl_bench.sv
module snoop_tag_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req_vld, cpu_wr, cpu_stall;
  logic [31:0] cpu_addr;
  logic        rsp_vld, rsp_hit;
  logic [1:0]  rsp_way, rsp_state;
  logic        miss_req_vld, miss_wb, miss_ack;
  logic [31:0] miss_addr;
  logic [1:0]  miss_way;
  logic        bus_ce, snp_vld, snp_snoopable;
  logic [31:0] snp_addr;

  always #4 clk = ~clk;

  snoop_tag_ctrl u_snoop_tag_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_vld(cpu_req_vld), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_stall(cpu_stall),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_state(rsp_state),
    .miss_req_vld(miss_req_vld), .miss_addr(miss_addr), .miss_way(miss_way),
    .miss_wb(miss_wb), .miss_ack(miss_ack),
    .bus_ce(bus_ce), .snp_vld(snp_vld), .snp_snoopable(snp_snoopable), .snp_addr(snp_addr));

  localparam logic [1:0] S_INV = 2'b00, S_CLN = 2'b01, S_DRT = 2'b11;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0;
  logic [4:0] exq[$];
  string      rqq[$];

  function automatic logic [31:0] mk(input int tag, input int set, input int off);
    return {22'(tag), 6'(set), 4'(off)};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // monitor: pops expected results as the design produces them
  always @(negedge clk) begin
    if (rst_n && rsp_vld) begin
      if (exq.size() == 0) chk(0, "R2", "response with nothing expected", 1, 0);
      else begin
        logic [4:0] e;
        string r;
        e = exq.pop_front();
        r = rqq.pop_front();
        chk({rsp_hit, rsp_way, rsp_state} == e, r, "hit/way/state",
            {27'd0, rsp_hit, rsp_way, rsp_state}, {27'd0, e});
      end
    end
  end

  task automatic lookup(input logic [31:0] a, input logic wr, input logic eh,
                        input logic [1:0] ew, input logic [1:0] es, input string rq);
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; cpu_req_vld = 1'b1;
    exq.push_back({eh, ew, es});
    rqq.push_back(rq);
    #1;
    while (cpu_stall) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    cpu_req_vld = 1'b0;
  endtask

  task automatic serve_miss(input logic [31:0] ea, input logic [1:0] ew,
                            input logic ewb, input string rq);
    @(negedge clk);
    chk(miss_req_vld == 1'b1, "R3", "miss request raised", miss_req_vld, 1);
    chk(miss_addr == {ea[31:4], 4'h0}, "R3", "miss line address", miss_addr, {ea[31:4], 4'h0});
    chk(miss_way == ew, rq, "miss victim way", miss_way, ew);
    chk(miss_wb == ewb, "R7", "writeback flag", miss_wb, ewb);
    cpu_addr = ea; cpu_wr = 1'b0; cpu_req_vld = 1'b1;
    #1;
    chk(cpu_stall == 1'b1, "R3", "stall while miss pending", cpu_stall, 1);
    cpu_req_vld = 1'b0;
    miss_ack = 1'b1;
    @(negedge clk);
    miss_ack = 1'b0;
    #1;
    chk(miss_req_vld == 1'b0, "R4", "miss request dropped after ack", miss_req_vld, 0);
  endtask

  task automatic snoop(input logic [31:0] a, input logic snoopable, input logic ce);
    @(negedge clk);
    snp_addr = a; snp_vld = 1'b1; snp_snoopable = snoopable; bus_ce = ce;
    @(negedge clk);
    snp_vld = 1'b0; snp_snoopable = 1'b0; bus_ce = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_req_vld = 1'b0; cpu_wr = 1'b0; cpu_addr = '0;
    miss_ack = 1'b0; bus_ce = 1'b1; snp_vld = 1'b0; snp_snoopable = 1'b0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rsp_vld == 1'b0, "R1", "rsp_vld after reset", rsp_vld, 0);
    chk(miss_req_vld == 1'b0, "R1", "miss_req_vld after reset", miss_req_vld, 0);
    chk(cpu_stall == 1'b0, "R1", "stall after reset", cpu_stall, 0);

    // fill set 5: ways 0..3, first read miss after reset (R1), lowest invalid way (R6)
    lookup(mk(1, 5, 0), 0, 0, 2'd0, S_INV, "R1");
    serve_miss(mk(1, 5, 0), 2'd0, 0, "R6");
    lookup(mk(1, 5, 8), 0, 1, 2'd0, S_CLN, "R11");
    lookup(mk(2, 5, 4), 1, 0, 2'd1, S_INV, "R3");
    serve_miss(mk(2, 5, 4), 2'd1, 0, "R6");
    lookup(mk(2, 5, 0), 0, 1, 2'd1, S_DRT, "R4");
    lookup(mk(1, 5, 0), 1, 1, 2'd0, S_DRT, "R5");
    lookup(mk(1, 5, 12), 0, 1, 2'd0, S_DRT, "R5");
    lookup(mk(1, 7, 0), 0, 0, 2'd0, S_INV, "R2");
    serve_miss(mk(1, 7, 0), 2'd0, 0, "R2");
    lookup(mk(3, 5, 0), 0, 0, 2'd2, S_INV, "R6");
    serve_miss(mk(3, 5, 0), 2'd2, 0, "R6");
    lookup(mk(4, 5, 0), 0, 0, 2'd3, S_INV, "R6");
    serve_miss(mk(4, 5, 0), 2'd3, 0, "R6");

    // full set: round-robin from 0, writeback of dirty victims (R7)
    lookup(mk(5, 5, 0), 0, 0, 2'd0, S_INV, "R6");
    serve_miss(mk(5, 5, 0), 2'd0, 1, "R6");
    lookup(mk(6, 5, 0), 0, 0, 2'd1, S_INV, "R7");
    serve_miss(mk(6, 5, 0), 2'd1, 1, "R7");
    lookup(mk(1, 5, 0), 0, 0, 2'd2, S_INV, "R6");
    serve_miss(mk(1, 5, 0), 2'd2, 0, "R6");
    // set 5 now: w0 tag5, w1 tag6, w2 tag1, w3 tag4, all clean; pointer at 3

    // ignored bus cycles (R9)
    snoop(mk(4, 5, 0), 0, 1);
    lookup(mk(4, 5, 0), 0, 1, 2'd3, S_CLN, "R9");
    snoop(mk(4, 5, 0), 1, 0);
    lookup(mk(4, 5, 0), 0, 1, 2'd3, S_CLN, "R9");

    // snoop invalidates way 1; hole preferred over pointer (R8, R6)
    snoop(mk(6, 5, 0), 1, 1);
    lookup(mk(6, 5, 0), 0, 0, 2'd1, S_INV, "R8");
    serve_miss(mk(6, 5, 0), 2'd1, 0, "R8");

    // collision: snoop and lookup of tag 5 in the same cycle (R10)
    @(negedge clk);
    snp_addr = mk(5, 5, 0); snp_vld = 1'b1; snp_snoopable = 1'b1; bus_ce = 1'b1;
    cpu_addr = mk(5, 5, 0); cpu_wr = 1'b0; cpu_req_vld = 1'b1;
    exq.push_back({1'b0, 2'd0, S_INV});
    rqq.push_back("R10");
    #1;
    chk(cpu_stall == 1'b1, "R10", "stall under snoop", cpu_stall, 1);
    @(negedge clk);
    chk(rsp_vld == 1'b0, "R10", "no response in snoop cycle", rsp_vld, 0);
    snp_vld = 1'b0; snp_snoopable = 1'b0;
    #1;
    chk(cpu_stall == 1'b0, "R10", "stall released", cpu_stall, 0);
    @(negedge clk);
    cpu_req_vld = 1'b0;
    serve_miss(mk(5, 5, 0), 2'd0, 0, "R10");

    // pointer did not move on hole fills: next full-set victim is way 3 (R6)
    lookup(mk(7, 5, 0), 0, 0, 2'd3, S_INV, "R6");
    serve_miss(mk(7, 5, 0), 2'd3, 0, "R6");
    lookup(mk(7, 5, 0), 0, 1, 2'd3, S_CLN, "R4");

    repeat (3) @(negedge clk);
    chk(exq.size() == 0, "R2", "all expected responses seen", exq.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule